// File: doc/BRIEF.md
# Bit-Masked PHY Control Register Bank

This block is the control and status register file for a display transmitter PHY. It sits on a simple single-port register bus. A write carries its own per-bit enable in the upper 16 bits of the data word. Only the low-half bits whose enable bit is set change, so software can update a single field without first reading the word back. The enable half is never stored.

The bank holds twelve 16-bit control words and exposes two read-only status words. The fields in the control words drive the analog PHY directly as parallel outputs. These cover per-lane idle and power-down, PLL power-down, PLL and reference dividers, the per-lane swing, scale and emphasis settings, spread-spectrum, and the AUX channel settings. Reads are registered, so the data appears one cycle after the request.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write to a control word, bit i (0..15) of that word takes wrData[i] when wrData[i+16] is 1 and keeps its value otherwise. A mask of all zeros changes nothing.
- R2: The word index is addr[5:2] and addr[1:0] are ignored. Indices 0..11 (byte offsets 0x00..0x2C) are control words. Index 12 (0x30) is status word 0, which reads pllReady in bit 0 and zero elsewhere. Index 13 (0x34) reads statusIn.
- R3: Word 0 drives laneIdle from [11:8], lanePwrDn from [7:4], iddqEn from bit 1 and pllPwrDn from bit 0.
- R4: For lane l (0..3), laneEmph[4l+3:4l] comes from word 3 [4l+3:4l] and laneAmp[3l+2:3l] from word 4 [4l+2:4l]. laneAmpScale[2l+1:2l] comes from word 5 [2l+1:2l], and txMode comes from word 5 [9:8].
- R5: Word 6 drives sscDepth from [15:12], sscEn from bit 11 and sscCount from [9:0].
- R6: Word 10 drives auxRcvPdSel (bit 5), auxDrvPdSel (bit 4), auxIdle (bit 2), auxRcvPd (bit 1) and auxDrvPd (bit 0). Word 11 drives auxRcvVcm [14:12], auxMode [11:10], auxAmpScale [9:8], auxAmp [6:4] and auxTerm [2:0].
- R7: Word 1 drives pllDiv from [14:0]. Word 2 drives txTerm [10:8], rateSel [5:4] and refDiv [3:0]. Words 8 and 9 drive pllCtl and txCtl over all 16 bits.
- R8: rdData updates on the clock edge that samples rdEn. Its upper half is zero and its lower half is the addressed word. It holds its value while rdEn is low. A read in the same cycle as a write to the same word returns the value from before the write.
- R9: Writes to indices 12..15 change no control word. Reads of indices 14 and 15 return zero.
- R10: A synchronous active-high rst clears every control word and rdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| addr | input | 6 | Byte address; word index in [5:2] |
| wrData | input | 32 | [31:16] bit enables, [15:0] new values |
| rdData | output | 32 | Registered read data, upper half zero |
| pllReady | input | 1 | PLL lock status |
| statusIn | input | 16 | Second status word |
| laneIdle | output | 4 | Per-lane transmit idle |
| lanePwrDn | output | 4 | Per-lane transmit power-down |
| iddqEn | output | 1 | Quiescent-current test enable |
| pllPwrDn | output | 1 | PLL power-down |
| pllDiv | output | 15 | PLL feedback divider |
| txTerm | output | 3 | Transmit termination select |
| rateSel | output | 2 | Link rate select |
| refDiv | output | 4 | Reference divider |
| laneEmph | output | 16 | Per-lane emphasis, 4 bits per lane |
| laneAmp | output | 12 | Per-lane amplitude, 3 bits per lane |
| laneAmpScale | output | 8 | Per-lane amplitude scale, 2 bits per lane |
| txMode | output | 2 | Transmit mode |
| sscDepth | output | 4 | Spread-spectrum depth |
| sscEn | output | 1 | Spread-spectrum enable |
| sscCount | output | 10 | Spread-spectrum step count |
| pllCtl | output | 16 | PLL control word |
| txCtl | output | 16 | Transmit control word |
| auxRcvPdSel | output | 1 | AUX receiver power-down source select |
| auxDrvPdSel | output | 1 | AUX driver power-down source select |
| auxIdle | output | 1 | AUX idle |
| auxRcvPd | output | 1 | AUX receiver power-down |
| auxDrvPd | output | 1 | AUX driver power-down |
| auxRcvVcm | output | 3 | AUX receiver common-mode select |
| auxMode | output | 2 | AUX mode |
| auxAmpScale | output | 2 | AUX amplitude scale |
| auxAmp | output | 3 | AUX amplitude |
| auxTerm | output | 3 | AUX termination select |

## Verification
The case that is hardest to reach from the ports is a partial mask over a word that already holds a mixed pattern. That is the only case where a wrong merge shows as a changed neighbour bit rather than a wrong target bit. The bench sweeps every control word through a sequence of writes whose values and masks are computed arithmetically, so most writes land on non-trivial prior contents. It includes an all-ones mask, an all-zero mask and irregular masks. After each write it compares a bench model against both the readback and every field output. A read issued in the same cycle as a write to that word is also driven, to pin down the ordering.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;
  localparam int BUS_W     = 32;
  localparam int HALF_W    = BUS_W / 2;
  localparam int ADDR_W    = 6;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int NUM_CTL   = 12;
  localparam int NUM_STS   = 2;
  localparam int NUM_WORDS = NUM_CTL + NUM_STS;
  localparam int NUM_LANES = 4;

  // control word indices the field slicing depends on
  localparam int W_POWER  = 0;
  localparam int W_PLLDIV = 1;
  localparam int W_CLKCFG = 2;
  localparam int W_EMPH   = 3;
  localparam int W_AMP    = 4;
  localparam int W_SCALE  = 5;
  localparam int W_SSC    = 6;
  localparam int W_PLLCTL = 8;
  localparam int W_TXCTL  = 9;
  localparam int W_AUXPWR = 10;
  localparam int W_AUXCFG = 11;

  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    logic [NUM_CTL-1:0] wrSel;
    half_t              wrMask;
    half_t              wrVal;
    logic               rdGo;
    logic               rdHit;
    logic [IDX_W-1:0]   rdIdx;
  } bank_strobe_t;
endpackage

// File: rtl/phy_regbank_ctl.sv
module phy_regbank_ctl
  import phy_regbank_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output bank_strobe_t      strobe
);
  logic [IDX_W-1:0] wordIdx;
  logic [NUM_CTL-1:0] selVec;
  logic unusedAddrLow;

  assign wordIdx       = addr[ADDR_W-1:2];
  assign unusedAddrLow = ^addr[1:0];

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_sel
    assign selVec[k] = wrEn && (wordIdx == IDX_W'(k));
  end

  always_comb begin
    strobe.wrSel  = selVec;
    strobe.wrMask = wrData[BUS_W-1:HALF_W];
    strobe.wrVal  = wrData[HALF_W-1:0];
    strobe.rdGo   = rdEn;
    strobe.rdHit  = wordIdx < IDX_W'(NUM_WORDS);
    strobe.rdIdx  = wordIdx;
  end
endmodule

// File: rtl/phy_regbank_dp.sv
module phy_regbank_dp
  import phy_regbank_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  bank_strobe_t                   strobe,
  input  logic                           pllReady,
  input  logic [HALF_W-1:0]              statusIn,
  output logic [NUM_CTL-1:0][HALF_W-1:0] bankWords,
  output logic [BUS_W-1:0]               rdData
);
  half_t rdWord;

  for (genvar w = 0; w < NUM_CTL; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        bankWords[w] <= '0;
      end else if (strobe.wrSel[w]) begin
        bankWords[w] <= (bankWords[w] & ~strobe.wrMask) |
                        (strobe.wrVal & strobe.wrMask);
      end
    end
  end

  always_comb begin
    rdWord = '0;
    if (strobe.rdHit) begin
      if (strobe.rdIdx < IDX_W'(NUM_CTL)) begin
        rdWord = bankWords[strobe.rdIdx];
      end else if (strobe.rdIdx == IDX_W'(NUM_CTL)) begin
        rdWord = {{(HALF_W-1){1'b0}}, pllReady};
      end else begin
        rdWord = statusIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobe.rdGo) begin
      rdData <= {{HALF_W{1'b0}}, rdWord};
    end
  end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_regbank_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BUS_W-1:0]            wrData,
  output logic [BUS_W-1:0]            rdData,
  input  logic                        pllReady,
  input  logic [HALF_W-1:0]           statusIn,
  output logic [NUM_LANES-1:0]        laneIdle,
  output logic [NUM_LANES-1:0]        lanePwrDn,
  output logic                        iddqEn,
  output logic                        pllPwrDn,
  output logic [14:0]                 pllDiv,
  output logic [2:0]                  txTerm,
  output logic [1:0]                  rateSel,
  output logic [3:0]                  refDiv,
  output logic [4*NUM_LANES-1:0]      laneEmph,
  output logic [3*NUM_LANES-1:0]      laneAmp,
  output logic [2*NUM_LANES-1:0]      laneAmpScale,
  output logic [1:0]                  txMode,
  output logic [3:0]                  sscDepth,
  output logic                        sscEn,
  output logic [9:0]                  sscCount,
  output logic [HALF_W-1:0]           pllCtl,
  output logic [HALF_W-1:0]           txCtl,
  output logic                        auxRcvPdSel,
  output logic                        auxDrvPdSel,
  output logic                        auxIdle,
  output logic                        auxRcvPd,
  output logic                        auxDrvPd,
  output logic [2:0]                  auxRcvVcm,
  output logic [1:0]                  auxMode,
  output logic [1:0]                  auxAmpScale,
  output logic [2:0]                  auxAmp,
  output logic [2:0]                  auxTerm
);
  bank_strobe_t strobe;
  logic [NUM_CTL-1:0][HALF_W-1:0] bankWords;
  logic unusedBankParity;

  phy_regbank_ctl u_ctl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .strobe (strobe)
  );

  phy_regbank_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .pllReady  (pllReady),
    .statusIn  (statusIn),
    .bankWords (bankWords),
    .rdData    (rdData)
  );

  assign unusedBankParity = ^bankWords;

  assign laneIdle  = bankWords[W_POWER][11:8];
  assign lanePwrDn = bankWords[W_POWER][7:4];
  assign iddqEn    = bankWords[W_POWER][1];
  assign pllPwrDn  = bankWords[W_POWER][0];

  assign pllDiv  = bankWords[W_PLLDIV][14:0];
  assign txTerm  = bankWords[W_CLKCFG][10:8];
  assign rateSel = bankWords[W_CLKCFG][5:4];
  assign refDiv  = bankWords[W_CLKCFG][3:0];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign laneEmph[4*l +: 4]     = bankWords[W_EMPH][4*l +: 4];
    assign laneAmp[3*l +: 3]      = bankWords[W_AMP][4*l +: 3];
    assign laneAmpScale[2*l +: 2] = bankWords[W_SCALE][2*l +: 2];
  end
  assign txMode = bankWords[W_SCALE][9:8];

  assign sscDepth = bankWords[W_SSC][15:12];
  assign sscEn    = bankWords[W_SSC][11];
  assign sscCount = bankWords[W_SSC][9:0];

  assign pllCtl = bankWords[W_PLLCTL];
  assign txCtl  = bankWords[W_TXCTL];

  assign auxRcvPdSel = bankWords[W_AUXPWR][5];
  assign auxDrvPdSel = bankWords[W_AUXPWR][4];
  assign auxIdle     = bankWords[W_AUXPWR][2];
  assign auxRcvPd    = bankWords[W_AUXPWR][1];
  assign auxDrvPd    = bankWords[W_AUXPWR][0];

  assign auxRcvVcm   = bankWords[W_AUXCFG][14:12];
  assign auxMode     = bankWords[W_AUXCFG][11:10];
  assign auxAmpScale = bankWords[W_AUXCFG][9:8];
  assign auxAmp      = bankWords[W_AUXCFG][6:4];
  assign auxTerm     = bankWords[W_AUXCFG][2:0];
endmodule

// File: rtl/phy_regbank_chk.sv
module phy_regbank_chk
  import phy_regbank_pkg::*;
(
  input logic                           clk,
  input logic                           rst,
  input logic                           wrEn,
  input logic                           rdEn,
  input logic [ADDR_W-1:0]              addr,
  input logic [BUS_W-1:0]               wrData,
  input logic [BUS_W-1:0]               rdData,
  input logic                           pllReady,
  input logic [NUM_CTL-1:0][HALF_W-1:0] bankWords
);
  logic [IDX_W-1:0] aIdx;
  assign aIdx = addr[ADDR_W-1:2];

  a_r1_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
    (wrEn && aIdx < IDX_W'(NUM_CTL)) |=>
      ((bankWords[$past(aIdx)] & ~$past(wrData[BUS_W-1:HALF_W])) ==
       ($past(bankWords[aIdx]) & ~$past(wrData[BUS_W-1:HALF_W]))));

  a_r1_masked_take: assert property (@(posedge clk) disable iff (rst)
    (wrEn && aIdx < IDX_W'(NUM_CTL)) |=>
      ((bankWords[$past(aIdx)] & $past(wrData[BUS_W-1:HALF_W])) ==
       ($past(wrData[HALF_W-1:0]) & $past(wrData[BUS_W-1:HALF_W]))));

  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wrEn && aIdx >= IDX_W'(NUM_CTL)) |=> $stable(bankWords));

  a_r1_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(bankWords));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rdData[BUS_W-1:HALF_W] == '0);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

  a_r2_pll_status: assert property (@(posedge clk) disable iff (rst)
    (rdEn && aIdx == IDX_W'(NUM_CTL)) |=> (rdData[0] == $past(pllReady)));
endmodule

bind phy_ctl_regbank phy_regbank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .pllReady  (pllReady),
  .bankWords (bankWords)
);

// File: tb/sim_phy_ctl_regbank.sv
`timescale 1ns/1ps
module sim_phy_ctl_regbank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic pllReady = 1'b0;
  logic [15:0] statusIn = '0;
  logic [3:0] laneIdle, lanePwrDn;
  logic iddqEn, pllPwrDn;
  logic [14:0] pllDiv;
  logic [2:0] txTerm;
  logic [1:0] rateSel;
  logic [3:0] refDiv;
  logic [15:0] laneEmph;
  logic [11:0] laneAmp;
  logic [7:0] laneAmpScale;
  logic [1:0] txMode;
  logic [3:0] sscDepth;
  logic sscEn;
  logic [9:0] sscCount;
  logic [15:0] pllCtl, txCtl;
  logic auxRcvPdSel, auxDrvPdSel, auxIdle, auxRcvPd, auxDrvPd;
  logic [2:0] auxRcvVcm;
  logic [1:0] auxMode, auxAmpScale;
  logic [2:0] auxAmp, auxTerm;

  int testsRun = 0;
  int testsFailed = 0;
  logic [15:0] mdl [12];
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  phy_ctl_regbank u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pllReady(pllReady), .statusIn(statusIn),
    .laneIdle(laneIdle), .lanePwrDn(lanePwrDn), .iddqEn(iddqEn), .pllPwrDn(pllPwrDn),
    .pllDiv(pllDiv), .txTerm(txTerm), .rateSel(rateSel), .refDiv(refDiv),
    .laneEmph(laneEmph), .laneAmp(laneAmp), .laneAmpScale(laneAmpScale),
    .txMode(txMode), .sscDepth(sscDepth), .sscEn(sscEn), .sscCount(sscCount),
    .pllCtl(pllCtl), .txCtl(txCtl), .auxRcvPdSel(auxRcvPdSel),
    .auxDrvPdSel(auxDrvPdSel), .auxIdle(auxIdle), .auxRcvPd(auxRcvPd),
    .auxDrvPd(auxDrvPd), .auxRcvVcm(auxRcvVcm), .auxMode(auxMode),
    .auxAmpScale(auxAmpScale), .auxAmp(auxAmp), .auxTerm(auxTerm)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] d);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = d[i+16] ? d[i] : old[i];
    return r;
  endfunction

  task automatic checkFields();
    check("R3 laneIdle", 32'(laneIdle), 32'(mdl[0][11:8]));
    check("R3 lanePwrDn", 32'(lanePwrDn), 32'(mdl[0][7:4]));
    check("R3 iddq/pllPd", 32'({iddqEn, pllPwrDn}), 32'(mdl[0][1:0]));
    check("R7 pllDiv", 32'(pllDiv), 32'(mdl[1][14:0]));
    check("R7 clkcfg", 32'({txTerm, rateSel, refDiv}),
          32'({mdl[2][10:8], mdl[2][5:4], mdl[2][3:0]}));
    for (int l = 0; l < 4; l++) begin
      check("R4 emph", 32'(laneEmph[4*l +: 4]), 32'(mdl[3][4*l +: 4]));
      check("R4 amp", 32'(laneAmp[3*l +: 3]), 32'(mdl[4][4*l +: 3]));
      check("R4 ampScale", 32'(laneAmpScale[2*l +: 2]), 32'(mdl[5][2*l +: 2]));
    end
    check("R4 txMode", 32'(txMode), 32'(mdl[5][9:8]));
    check("R5 ssc", 32'({sscDepth, sscEn, sscCount}),
          32'({mdl[6][15:12], mdl[6][11], mdl[6][9:0]}));
    check("R7 pllCtl/txCtl", {pllCtl, txCtl}, {mdl[8], mdl[9]});
    check("R6 auxPwr", 32'({auxRcvPdSel, auxDrvPdSel, auxIdle, auxRcvPd, auxDrvPd}),
          32'({mdl[10][5:4], mdl[10][2:0]}));
    check("R6 auxCfg", 32'({auxRcvVcm, auxMode, auxAmpScale, auxAmp, auxTerm}),
          32'({mdl[11][14:12], mdl[11][11:8], mdl[11][6:4], mdl[11][2:0]}));
  endtask

  task automatic checkAllReadback(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 12; w++) begin
      busRead(6'(w*4), d);
      check(tag, d, {16'h0, mdl[w]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int w = 0; w < 12; w++) mdl[w] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 rdData reset", rdData, 32'h0);
    checkFields();
    checkAllReadback("R10 words reset");

    // R1/R8: masked write sweep over all control words
    for (int w = 0; w < 12; w++) begin
      for (int p = 0; p < 8; p++) begin
        logic [15:0] v, m;
        logic [31:0] d;
        v = 16'((w * 4951 + p * 12059)) ^ 16'hA5C3;
        m = (p == 0) ? 16'hFFFF : (p == 7) ? 16'h0000 :
            16'((p * 7919 + w * 173)) ^ 16'h3C96;
        busWrite(6'(w*4), {m, v});
        mdl[w] = merge(mdl[w], {m, v});
        checkFields();
        busRead(6'(w*4), d);
        check("R1 masked readback", d, {16'h0, mdl[w]});
      end
    end
    checkAllReadback("R1 sweep final");

    // R2: low address bits ignored
    busWrite(6'(2*4 + 3), 32'hFFFF_0735);
    mdl[2] = 16'h0735;
    busRead(6'(2*4 + 1), rv);
    check("R2 low addr bits ignored", rv, 32'h0000_0735);
    checkFields();

    // R9: writes to status and unmapped indices ignored
    for (int i = 12; i < 16; i++) busWrite(6'(i*4), 32'hFFFF_FFFF);
    checkAllReadback("R9 status write ignored");
    checkFields();
    busRead(6'(14*4), rv); check("R9 unmapped read 14", rv, 32'h0);
    busRead(6'(15*4), rv); check("R9 unmapped read 15", rv, 32'h0);

    // R2: status words
    pllReady = 1'b1; statusIn = 16'hBEEF;
    busRead(6'(12*4), rv); check("R2 pll ready 1", rv, 32'h1);
    busRead(6'(13*4), rv); check("R2 status word 1", rv, 32'h0000_BEEF);
    pllReady = 1'b0; statusIn = 16'h1234;
    busRead(6'(12*4), rv); check("R2 pll ready 0", rv, 32'h0);
    busRead(6'(13*4), rv); check("R2 status word 1b", rv, 32'h0000_1234);

    // R8: hold while idle
    repeat (3) @(negedge clk);
    check("R8 rdData holds", rdData, 32'h0000_1234);

    // R8: read and write same word in one cycle returns the old value
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 6'(10*4); wrData = 32'h00FF_0037;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R8 same-cycle old value", rdData, {16'h0, mdl[10]});
    mdl[10] = merge(mdl[10], 32'h00FF_0037);
    busRead(6'(10*4), rv);
    check("R8 same-cycle new value", rv, {16'h0, mdl[10]});
    checkFields();

    // R10: mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int w = 0; w < 12; w++) mdl[w] = '0;
    check("R10 rdData after reset", rdData, 32'h0);
    checkFields();
    checkAllReadback("R10 words after reset");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule